// File: doc/BRIEF.md
# Four-Channel Capture/Compare Timer

This block is a general-purpose timer built around one 16-bit up-counter. The counter advances once per timer tick, and a programmable power-of-two divider derives the tick from the bus clock. Four channels share the counter. Each channel works either as a capture unit or as a compare unit. As a capture unit it records the counter value when its input pin sees a rising edge. As a compare unit it toggles its output pin when the counter reaches the channel's stored value.

Each channel has an event flag. Software clears a flag by writing a one to it. An optional fast-clear mode also clears a flag when software accesses that channel's data register. A per-channel enable selects which flags reach the single interrupt line. A compare match on the highest channel can restart the counter, which turns the block into a programmable-period generator.

Software reaches the block through a simple register bus with a 4-bit address. The read data is a combinational function of the address. A write takes effect at the clock edge where the write strobe is high. A read strobe only matters for fast clear.

Top module: `cc_timer4`

## Requirements
- R1: The prescaler select field is CTRL (address 0) bits 2:0, value p. The counter (read at address 4) advances by exactly one every 2^p bus clocks, and it wraps from 0xFFFF to 0.
- R2: A new select value does not cut the divide period already running. It takes effect from the tick after the next prescaler rollover.
- R3: Address 1 holds one mode bit per channel, where 0 means capture. In capture mode, a rising edge on cap_i[n] stores the counter value into the channel register (address 8+n) on the first tick at or after the edge, and sets flag n. If a capture and a software write to the same register fall in the same cycle, the capture wins.
- R4: Mode bit 1 means compare. In compare mode, on a tick where the counter equals the channel register, cmp_o[n] toggles and flag n sets. Otherwise cmp_o[n] does not change.
- R5: CTRL bit 3 is the counter-restart enable. When it is 1, a compare match on channel 3 loads the counter with 0 instead of incrementing it. When it is 0, the counter runs on past the match.
- R6: The flag register (address 3) holds flag n in bit n. Writing 1 to a bit clears that flag, and writing 0 has no effect. Bits 15:4 read as 0.
- R7: CTRL bit 4 is the fast-clear enable. When it is set, a read strobe on a capture-mode channel register clears that channel's flag, and a write to a compare-mode channel register clears that channel's flag.
- R8: When a flag-set event and any clearing access fall in the same cycle, the flag ends up set.
- R9: Address 2 holds one interrupt enable per channel. irq_o is high exactly when some flag is set together with its enable.
- R10: After reset, every register, the counter, cmp_o and irq_o are 0, and the prescaler divides by 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_i | input | 4 | Register address |
| wdata_i | input | 16 | Write data |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe (matters only for fast clear) |
| rdata_o | output | 16 | Read data for addr_i |
| cap_i | input | 4 | Capture inputs, one per channel |
| cmp_o | output | 4 | Compare outputs, one per channel |
| irq_o | output | 1 | Interrupt request |

## Verification
A flag can be set by a channel event in the same cycle that software clears it. The clear can come from a write-one to the flag register, a fast-clear read, or a fast-clear write. The bench provokes the first case exactly: it loads a compare value a few counts ahead of the counter, waits on its reference model until the matching tick is the next edge, and issues the clearing write on that edge. The flag must then read back as set. Captures that coincide with register writes, and compare matches that coincide with fast-clear writes, are judged every cycle against the same reference model.

// File: rtl/cct_pkg.sv
// Shared constants for the capture/compare timer: register addresses and
// control bit positions. Assumes a 4-bit register address space.
package cct_pkg;
    localparam int ADDR_W     = 4;
    localparam int A_CTRL     = 0;
    localparam int A_MODE     = 1;
    localparam int A_IEN      = 2;
    localparam int A_FLAG     = 3;
    localparam int A_COUNT    = 4;
    localparam int A_CHAN     = 8;
    localparam int CB_CNTRST  = 3;
    localparam int CB_FASTCLR = 4;
endpackage

// File: rtl/cct_prescaler.sv
// Power-of-two tick divider. A tick comes every 2^act bus clocks, where act
// is a shadow copy of the select input. The shadow updates only at a
// rollover, so a select change never shortens the current period.
module cct_prescaler #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel_i,
    output logic             tick_o
);
    localparam int DIV_W = (1 << SEL_W) - 1;

    logic [SEL_W-1:0] act_q;
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] lim;

    // terminal count for the active division
    always_comb begin
        lim    = ~({DIV_W{1'b1}} << act_q);
        tick_o = (div_q == lim);
    end

    // divide counter and shadowed select
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
            act_q <= '0;
        end else if (tick_o) begin
            div_q <= '0;
            act_q <= sel_i;
        end else begin
            div_q <= div_q + DIV_W'(1);
        end
    end
endmodule

// File: rtl/cct_counter.sv
// Free-running timer counter. It advances on each tick, or loads zero on a
// tick when a restart is requested.
module cct_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  logic         zero_i,
    output logic [W-1:0] cnt_o
);
    // count or restart on tick
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_o <= '0;
        else if (tick_i) cnt_o <= zero_i ? '0 : cnt_o + W'(1);
    end
endmodule

// File: rtl/cct_channel.sv
// One capture/compare channel. In capture mode, a rising edge is held
// pending until the next tick, which stores the counter. In compare mode, an
// equal count on a tick toggles the output. Assumes cap_i is already
// synchronous to clk.
module cct_channel #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  logic         is_cmp_i,
    input  logic [W-1:0] cnt_i,
    input  logic         cap_i,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] val_o,
    output logic         out_o,
    output logic         hit_o,
    output logic         cmp_hit_o
);
    logic pin_q, pend_q, rise, cap_hit;

    // event detection for both modes
    always_comb begin
        rise      = cap_i & ~pin_q;
        cap_hit   = ~is_cmp_i & tick_i & (pend_q | rise);
        cmp_hit_o = is_cmp_i & tick_i & (cnt_i == val_o);
        hit_o     = cap_hit | cmp_hit_o;
    end

    // pin history, pending edge, channel register, compare output
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_q  <= 1'b0;
            pend_q <= 1'b0;
            val_o  <= '0;
            out_o  <= 1'b0;
        end else begin
            pin_q <= cap_i;
            if (tick_i)    pend_q <= 1'b0;
            else if (rise) pend_q <= 1'b1;
            if (cap_hit)   val_o <= cnt_i;
            else if (wr_i) val_o <= wdata_i;
            if (cmp_hit_o) out_o <= ~out_o;
        end
    end
endmodule

// File: rtl/cc_timer4.sv
// Four-channel capture/compare timer top. It holds the control, mode,
// enable and flag registers, decodes the register bus and joins the
// prescaler, counter and channels. Read data is combinational on the address.
module cc_timer4
    import cct_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int CNT_W = 16,
    parameter int PS_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [CNT_W-1:0]  wdata_i,
    input  logic              wr_i,
    input  logic              rd_i,
    output logic [CNT_W-1:0]  rdata_o,
    input  logic [NCH-1:0]    cap_i,
    output logic [NCH-1:0]    cmp_o,
    output logic              irq_o
);
    localparam int CTRL_W = CB_FASTCLR + 1;

    logic [CTRL_W-1:0] ctrl_q;
    logic [NCH-1:0]    mode_q, ien_q, flag_q;
    logic [NCH-1:0]    hit_v, cmp_hit_v, chan_wr, chan_rd, fclr, w1c;
    logic [CNT_W-1:0]  ch_val [NCH];
    logic [CNT_W-1:0]  cnt_q;
    logic              tick, restart;

    cct_prescaler #(.SEL_W(PS_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .sel_i(ctrl_q[PS_W-1:0]), .tick_o(tick)
    );

    assign restart = ctrl_q[CB_CNTRST] & cmp_hit_v[NCH-1];

    cct_counter #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .zero_i(restart), .cnt_o(cnt_q)
    );

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        cct_channel #(.W(CNT_W)) u_ch (
            .clk(clk), .rst_n(rst_n), .tick_i(tick), .is_cmp_i(mode_q[n]),
            .cnt_i(cnt_q), .cap_i(cap_i[n]), .wr_i(chan_wr[n]),
            .wdata_i(wdata_i), .val_o(ch_val[n]), .out_o(cmp_o[n]),
            .hit_o(hit_v[n]), .cmp_hit_o(cmp_hit_v[n])
        );
    end

    // channel access decode and flag clear sources
    always_comb begin
        for (int n = 0; n < NCH; n++) begin
            chan_wr[n] = wr_i && (addr_i == ADDR_W'(A_CHAN + n));
            chan_rd[n] = rd_i && (addr_i == ADDR_W'(A_CHAN + n));
            fclr[n]    = ctrl_q[CB_FASTCLR] &&
                         ((chan_rd[n] && !mode_q[n]) || (chan_wr[n] && mode_q[n]));
        end
        w1c = (wr_i && addr_i == ADDR_W'(A_FLAG)) ? wdata_i[NCH-1:0] : '0;
    end

    // configuration and flag registers; a set beats a clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            mode_q <= '0;
            ien_q  <= '0;
            flag_q <= '0;
        end else begin
            if (wr_i && addr_i == ADDR_W'(A_CTRL)) ctrl_q <= wdata_i[CTRL_W-1:0];
            if (wr_i && addr_i == ADDR_W'(A_MODE)) mode_q <= wdata_i[NCH-1:0];
            if (wr_i && addr_i == ADDR_W'(A_IEN))  ien_q  <= wdata_i[NCH-1:0];
            flag_q <= (flag_q & ~(w1c | fclr)) | hit_v;
        end
    end

    // read mux
    always_comb begin
        rdata_o = '0;
        case (addr_i)
            ADDR_W'(A_CTRL):  rdata_o = CNT_W'(ctrl_q);
            ADDR_W'(A_MODE):  rdata_o = CNT_W'(mode_q);
            ADDR_W'(A_IEN):   rdata_o = CNT_W'(ien_q);
            ADDR_W'(A_FLAG):  rdata_o = CNT_W'(flag_q);
            ADDR_W'(A_COUNT): rdata_o = cnt_q;
            default: begin
                for (int n = 0; n < NCH; n++)
                    if (addr_i == ADDR_W'(A_CHAN + n)) rdata_o = ch_val[n];
            end
        endcase
    end

    // interrupt combine
    assign irq_o = |(flag_q & ien_q);
endmodule

// File: rtl/cct_checker.sv
// Temporal properties of the timer, attached to the top by bind.
module cct_checker #(
    parameter int NCH   = 4,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic [CNT_W-1:0] cnt_q,
    input logic [NCH-1:0]   flag_q,
    input logic [NCH-1:0]   ien_q,
    input logic [NCH-1:0]   hit_v,
    input logic [NCH-1:0]   cmp_hit_v,
    input logic [NCH-1:0]   cmp_o,
    input logic             irq_o,
    input logic             wr_i,
    input logic             rd_i,
    input logic             rst_en
);
    assert_cnt_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(tick) && !($past(rst_en) && $past(cmp_hit_v[NCH-1]))
        |-> cnt_q == $past(cnt_q) + CNT_W'(1));

    assert_cnt_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(tick) |-> $stable(cnt_q));

    assert_out_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(tick) |-> $stable(cmp_o));

    assert_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(tick) && $past(rst_en) && $past(cmp_hit_v[NCH-1])
        |-> cnt_q == '0);

    assert_clear_needs_access_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && (|($past(flag_q) & ~flag_q)) |-> $past(wr_i) || $past(rd_i));

    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ($past(hit_v) & ~flag_q) == '0);

    assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ien_q == '0 |-> !irq_o);
endmodule

bind cc_timer4 cct_checker #(.NCH(NCH), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_q(cnt_q), .flag_q(flag_q),
    .ien_q(ien_q), .hit_v(hit_v), .cmp_hit_v(cmp_hit_v), .cmp_o(cmp_o),
    .irq_o(irq_o), .wr_i(wr_i), .rd_i(rd_i), .rst_en(ctrl_q[cct_pkg::CB_CNTRST])
);

// File: tb/cc_timer4_bench.sv
// Reference-model bench: a behavioural model advances on every rising edge.
// All outputs are compared with it shortly after every falling edge.
module cc_timer4_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  addr;
    logic [15:0] wdata;
    logic        wr, rd;
    logic [15:0] rdata;
    logic [3:0]  cap;
    logic [3:0]  cmp;
    logic        irq;

    always #5 clk = ~clk;

    cc_timer4 u_cc_timer4 (
        .clk(clk), .rst_n(rst_n), .addr_i(addr), .wdata_i(wdata), .wr_i(wr),
        .rd_i(rd), .rdata_o(rdata), .cap_i(cap), .cmp_o(cmp), .irq_o(irq)
    );

    int    n_chk = 0, n_fail = 0;
    bit    done = 0;
    string phase = "R10 reset";

    // reference model state
    bit [15:0] m_cnt;
    bit [15:0] m_reg [4];
    bit [15:0] nreg [4];
    bit [3:0]  m_flag, m_mode, m_ien, m_out, m_prev, m_pend;
    bit [3:0]  setv, clr, nout, ed;
    bit [4:0]  m_ctrl;
    bit [2:0]  m_act;
    int        m_pc;
    bit        tk, rst3;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_flag = 0; m_mode = 0; m_ien = 0; m_out = 0;
            m_prev = 0; m_pend = 0; m_ctrl = 0; m_act = 0; m_pc = 0;
            for (int i = 0; i < 4; i++) m_reg[i] = 0;
        end else begin
            tk = (m_pc == (1 << m_act) - 1);
            ed = cap & ~m_prev;
            setv = 0; clr = 0; nout = m_out; rst3 = 0;
            for (int i = 0; i < 4; i++) nreg[i] = m_reg[i];
            for (int i = 0; i < 4; i++) begin
                if (!m_mode[i]) begin
                    if (tk && (m_pend[i] || ed[i])) begin nreg[i] = m_cnt; setv[i] = 1; end
                end else if (tk && m_cnt == m_reg[i]) begin
                    nout[i] = ~nout[i]; setv[i] = 1;
                    if (i == 3 && m_ctrl[3]) rst3 = 1;
                end
                m_pend[i] = tk ? 1'b0 : (m_pend[i] | ed[i]);
            end
            if (wr && addr == 3) clr |= wdata[3:0];
            if (wr && addr >= 8 && addr <= 11) begin
                if (!(setv[addr-8] && !m_mode[addr-8])) nreg[addr-8] = wdata;
                if (m_ctrl[4] && m_mode[addr-8]) clr[addr-8] = 1;
            end
            if (rd && addr >= 8 && addr <= 11 && m_ctrl[4] && !m_mode[addr-8]) clr[addr-8] = 1;
            m_flag = (m_flag & ~clr) | setv;
            if (tk) begin
                m_cnt = rst3 ? 16'd0 : m_cnt + 16'd1;
                m_pc = 0; m_act = m_ctrl[2:0];
            end else m_pc++;
            if (wr && addr == 0) m_ctrl = wdata[4:0];
            if (wr && addr == 1) m_mode = wdata[3:0];
            if (wr && addr == 2) m_ien = wdata[3:0];
            for (int i = 0; i < 4; i++) m_reg[i] = nreg[i];
            m_out = nout; m_prev = cap;
        end
    end

    function automatic bit [15:0] m_read(input bit [3:0] a);
        case (a)
            0: return {11'd0, m_ctrl};
            1: return {12'd0, m_mode};
            2: return {12'd0, m_ien};
            3: return {12'd0, m_flag};
            4: return m_cnt;
            8, 9, 10, 11: return m_reg[a-8];
            default: return 16'd0;
        endcase
    endfunction

    function automatic string rtag(input bit [3:0] a);
        if (a == 4) return "R1 count";
        if (a == 3) return "R6 flags";
        if (a >= 8 && a <= 11) return "R3 channel register";
        return "R10 config";
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s [%s] actual %0h expected %0h", req, phase, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        #2;
        if (rst_n && !done) begin
            chk(cmp == m_out, "R4 compare outputs", cmp, m_out);
            chk(irq == |(m_flag & m_ien), "R9 interrupt", irq, |(m_flag & m_ien));
            chk(rdata == m_read(addr), rtag(addr), rdata, m_read(addr));
        end
    end

    task automatic idle(input int k);
        repeat (k) begin @(negedge clk); wr = 0; rd = 0; addr = 4; end
    endtask

    task automatic wreg(input bit [3:0] a, input bit [15:0] d);
        @(negedge clk); addr = a; wdata = d; wr = 1; rd = 0;
        @(negedge clk); wr = 0; addr = 4;
    endtask

    task automatic rreg(input bit [3:0] a);
        @(negedge clk); addr = a; rd = 1; wr = 0;
        @(negedge clk); rd = 0; addr = 4;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        #2000000;
        if (!done) begin
            done = 1; n_fail++; n_chk++;
            $display("FAIL R10 watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        bit [15:0] tgt;
        rst_n = 0; wr = 0; rd = 0; addr = 4; wdata = 0; cap = 0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        #2;
        chk(rdata == 16'd0, "R10 count after reset", rdata, 0);
        chk(cmp == 4'd0, "R10 compare outputs after reset", cmp, 0);
        chk(irq == 1'b0, "R10 interrupt after reset", irq, 0);
        idle(3);

        phase = "R1 divide by 4";
        wreg(0, 16'h0002); idle(60);

        phase = "R2 select change mid-period";
        wreg(0, 16'h0007); idle(50);
        wreg(0, 16'h0001); idle(300);
        wreg(0, 16'h0000); idle(20);

        phase = "R4 compare toggling";
        wreg(2, 16'h000F); wreg(1, 16'h000F);
        for (int i = 0; i < 4; i++) wreg(4'(8 + i), m_cnt + 16'(12 + 3 * i));
        idle(40);

        phase = "R6 write one to clear";
        wreg(3, 16'h0005); rreg(3);
        wreg(3, 16'hFFF0); rreg(3);
        @(negedge clk); addr = 3; #1;
        chk(rdata[15:4] == 12'd0, "R6 upper flag bits", rdata[15:4], 0);
        wreg(3, 16'h000A); idle(3);

        phase = "R5 restart on channel 3";
        wreg(0, 16'h0008); wreg(11, m_cnt + 16'd15); idle(100);
        phase = "R5 restart disabled";
        wreg(0, 16'h0000); idle(30);

        phase = "R3 capture";
        wreg(0, 16'h0003); wreg(1, 16'h0000); wreg(3, 16'h000F);
        for (int k = 0; k < 8; k++) begin
            @(negedge clk); cap = 4'b0001 << (k % 4);
            @(negedge clk); cap = 0;
            idle(5 + k);
        end
        @(negedge clk); cap = 4'hF; @(negedge clk); cap = 0; idle(10);
        @(negedge clk); cap = 4'h2; @(negedge clk); cap = 0;
        @(negedge clk); cap = 4'h2; wr = 1; addr = 9; wdata = 16'hBEEF;
        @(negedge clk); cap = 0; wr = 0; addr = 4; idle(12);

        phase = "R7 fast clear";
        wreg(0, 16'h0010);
        @(negedge clk); cap = 4'hF; @(negedge clk); cap = 0; idle(4);
        rreg(8); rreg(9); wreg(3, 16'h000C);
        wreg(1, 16'h000F); idle(40);
        wreg(10, 16'h1234); wreg(8, 16'h0000); idle(10);

        phase = "R8 set beats clear";
        wreg(0, 16'h0000); wreg(1, 16'h0001); wreg(3, 16'h000F);
        tgt = m_cnt + 16'd8;
        wreg(8, tgt);
        forever begin
            @(negedge clk); #1;
            if (m_cnt == tgt) break;
        end
        addr = 3; wdata = 16'h0001; wr = 1;
        @(negedge clk); wr = 0; addr = 3; #1;
        chk(rdata[0] == 1'b1, "R8 flag kept on same-cycle clear", rdata[0], 1);
        idle(3);

        phase = "R9 interrupt masking";
        wreg(2, 16'h0000); idle(5);
        wreg(2, 16'h0001); idle(5);

        done = 1;
        summary();
        $finish;
    end
endmodule